// File: doc/BRIEF.md
# Memory-Mapped I/O Register Port

This block serves one 16-bit port of a word memory, with the interface modelled as synchronous. An access is taken at a rising clock edge when chip select is high. The access carries read/write, output enable, upper and lower byte-lane enables, an active-low register-overlay enable and a word address. When the overlay enable is high, the whole address range is plain memory with byte-lane masking. When it is low, two special registers cover the lowest two addresses. Address 0 is an input register that samples two external input pins through a two-flop synchronizer. Address 1 is a five-bit output register that drives external output pins and can be read back. Any write to the output register is also written into memory word 1.

Read data is registered. It appears on `rdata_o`, together with `rvalid_o`, in the cycle after the edge that took the read. At all other times the data output is zero.

Top module: `mmio_reg_port`

## Requirements
- R1: While reset is asserted, and at the first sample after it, `ext_out_o` is 0, `rvalid_o` is 0 and `rdata_o` is 0.
- R2: With `regmode_ni` high, every address from 0 to the maximum reads and writes the memory. Writes to addresses 0 and 1 in this mode leave `ext_out_o` unchanged.
- R3: On a memory write, `lb_i` enables writing of data bits 7:0 and `ub_i` enables writing of bits 15:8. A lane whose enable is low keeps its stored byte.
- R4: On a memory read, a byte lane whose enable is low returns zero on `rdata_o`.
- R5: A read with `cs_i`, `oe_i` and at least one enabled lane, taken at edge N, gives `rvalid_o` high and the data from edge N until edge N+1. A write, a read with `oe_i` low, or an idle cycle gives `rvalid_o` 0 and `rdata_o` 0 after its edge.
- R6: With `regmode_ni` low, a read at address 0 returns the synchronized inputs on bits 1:0, with bits 15:2 zero. A pin change made just before edge K is first returned by a read taken at edge K+2.
- R7: With `regmode_ni` low, a write at address 1 loads `wdata_i[4:0]` into the output register, and `ext_out_o` shows it after that edge. A read at address 1 returns it on bits 4:0, with bits 15:5 zero.
- R8: A write to the output register also writes `wdata_i` into memory word 1, under the same byte-lane masking as R3.
- R9: With `regmode_ni` low, a read or write at address 0 or 1 with `lb_i` low has no effect. A read gives `rvalid_o` 0. A write changes neither `ext_out_o` nor memory word 1.
- R10: With `regmode_ni` low, a write at address 0 and any access at address 2 or above go to the memory.
- R11: With `cs_i` low, nothing is written and `rvalid_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Chip select, high to access |
| we_i | input | 1 | 1 = write, 0 = read |
| oe_i | input | 1 | Output enable for reads |
| ub_i | input | 1 | Upper byte lane enable (bits 15:8) |
| lb_i | input | 1 | Lower byte lane enable (bits 7:0) |
| regmode_ni | input | 1 | Low to overlay the registers at addresses 0 and 1 |
| addr_i | input | 8 | Word address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Registered read data, zero when not valid |
| rvalid_o | output | 1 | Read data valid |
| ext_in_i | input | 2 | External input pins |
| ext_out_o | output | 5 | External output pins |

## Verification
The output-register load and the memory write-through to word 1 happen on the same edge. The bench provokes this with overlay writes to address 1 under different lane masks. It judges the result from the pins in the next cycle, then from a plain memory read of word 1. A write that carries only the upper lane enable must touch neither the pins nor the stored word. This shows that the lower-lane gate covers both paths.

// File: rtl/mmio_pkg.sv
package mmio_pkg;
  typedef enum logic [1:0] {
    SEL_MEM = 2'd0,
    SEL_IN  = 2'd1,
    SEL_OUT = 2'd2
  } rd_sel_e;
endpackage

// File: rtl/mmio_decode.sv
module mmio_decode
  import mmio_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          cs_i,
  input  logic          we_i,
  input  logic          oe_i,
  input  logic          ub_i,
  input  logic          lb_i,
  input  logic          regmode_ni,
  input  logic [AW-1:0] addr_i,
  output logic          mem_we_o,
  output logic [1:0]    mem_be_o,
  output logic          mem_re_o,
  output logic          out_we_o,
  output rd_sel_e       rd_sel_o,
  output logic          rd_en_o
);
  logic at_in, at_out, reg_rd_hit, reg_wr_hit;

  assign at_in      = (addr_i == AW'(0));
  assign at_out     = (addr_i == AW'(1));
  assign reg_rd_hit = cs_i & ~we_i & ~regmode_ni & (at_in | at_out);
  assign reg_wr_hit = cs_i &  we_i & ~regmode_ni & at_out;

  // register write needs the low lane; it also writes memory word 1
  assign out_we_o = reg_wr_hit & lb_i;
  assign mem_we_o = cs_i & we_i & (~reg_wr_hit | lb_i);
  assign mem_be_o = {ub_i, lb_i};

  assign rd_en_o  = cs_i & ~we_i & oe_i & (reg_rd_hit ? lb_i : (lb_i | ub_i));
  assign mem_re_o = rd_en_o & ~reg_rd_hit;
  assign rd_sel_o = !reg_rd_hit ? SEL_MEM : (at_in ? SEL_IN : SEL_OUT);
endmodule

// File: rtl/mmio_word_ram.sv
module mmio_word_ram #(
  parameter int DEPTH = 256,
  parameter int DW    = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int NB   = DW / 8
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic          re_i,
  input  logic [NB-1:0] be_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  for (genvar g = 0; g < NB; g++) begin : g_lane
    logic [7:0] mem [DEPTH];
    logic [7:0] rd_q;

    always_ff @(posedge clk_i) begin
      if (we_i && be_i[g]) mem[addr_i] <= wdata_i[g*8 +: 8];
      if (re_i)            rd_q        <= mem[addr_i];
    end

    assign rdata_o[g*8 +: 8] = rd_q;
  end
endmodule

// File: rtl/mmio_io_regs.sv
module mmio_io_regs #(
  parameter int IN_W   = 2,
  parameter int OUT_W  = 5,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IN_W-1:0]  ext_in_i,
  input  logic             out_we_i,
  input  logic [OUT_W-1:0] out_wdata_i,
  output logic [IN_W-1:0]  in_q_o,
  output logic [OUT_W-1:0] out_q_o
);
  logic [IN_W-1:0] sync_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_sync
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     sync_q[s] <= '0;
      else if (s == 0) sync_q[s] <= ext_in_i;
      else             sync_q[s] <= sync_q[(s == 0) ? 0 : s-1];
    end
  end

  assign in_q_o = sync_q[STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       out_q_o <= '0;
    else if (out_we_i) out_q_o <= out_wdata_i;
  end

  // R7
  out_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_we_i |=> out_q_o == $past(out_wdata_i));

  // R9
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_we_i |=> $stable(out_q_o));
endmodule

// File: rtl/mmio_reg_port.sv
module mmio_reg_port
  import mmio_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int DW    = 16,
  parameter int IN_W  = 2,
  parameter int OUT_W = 5,
  localparam int AW   = $clog2(DEPTH),
  localparam int NB   = DW / 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_i,
  input  logic             we_i,
  input  logic             oe_i,
  input  logic             ub_i,
  input  logic             lb_i,
  input  logic             regmode_ni,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  output logic             rvalid_o,
  input  logic [IN_W-1:0]  ext_in_i,
  output logic [OUT_W-1:0] ext_out_o
);
  logic          mem_we, mem_re, out_we, rd_en;
  logic [1:0]    mem_be;
  rd_sel_e       rd_sel, sel_q;
  logic [DW-1:0] ram_q, reg_q, lane_mask;
  logic [NB-1:0] be_q;
  logic          rvalid_q;
  logic [IN_W-1:0] in_q;

  mmio_decode #(.AW(AW)) u_dec (
    .cs_i, .we_i, .oe_i, .ub_i, .lb_i, .regmode_ni, .addr_i,
    .mem_we_o(mem_we), .mem_be_o(mem_be), .mem_re_o(mem_re),
    .out_we_o(out_we), .rd_sel_o(rd_sel), .rd_en_o(rd_en)
  );

  mmio_word_ram #(.DEPTH(DEPTH), .DW(DW)) u_ram (
    .clk_i, .we_i(mem_we), .re_i(mem_re), .be_i(NB'(mem_be)),
    .addr_i, .wdata_i, .rdata_o(ram_q)
  );

  mmio_io_regs #(.IN_W(IN_W), .OUT_W(OUT_W)) u_regs (
    .clk_i, .rst_ni, .ext_in_i, .out_we_i(out_we),
    .out_wdata_i(wdata_i[OUT_W-1:0]), .in_q_o(in_q), .out_q_o(ext_out_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      sel_q    <= SEL_MEM;
      be_q     <= '0;
      reg_q    <= '0;
    end else begin
      rvalid_q <= rd_en;
      if (rd_en) begin
        sel_q <= rd_sel;
        be_q  <= NB'(mem_be);
        reg_q <= (rd_sel == SEL_IN) ? DW'(in_q) : DW'(ext_out_o);
      end
    end
  end

  for (genvar g = 0; g < NB; g++) begin : g_mask
    assign lane_mask[g*8 +: 8] = {8{be_q[g]}};
  end

  assign rvalid_o = rvalid_q;
  assign rdata_o  = !rvalid_q ? '0 : (sel_q == SEL_MEM) ? (ram_q & lane_mask) : reg_q;

  // R5
  rd_needs_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cs_i && !we_i && oe_i) |=> !rvalid_o && rdata_o == '0);

  // R9
  reg_lb_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && !we_i && !regmode_ni && !lb_i && addr_i < AW'(2)) |=> !rvalid_o);

  // R8
  write_through_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_we |-> mem_we && mem_be[0] && addr_i == AW'(1));

  // R11
  idle_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_i |-> !mem_we && !out_we);
endmodule

// File: tb/mmio_reg_port_test.sv
module mmio_reg_port_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cs = 0, we = 0, oe = 0, ub = 0, lb = 0, regn = 1;
  logic [7:0]  addr = '0;
  logic [15:0] wd = '0, rdata;
  logic        rvalid;
  logic [1:0]  ext_in = '0;
  logic [4:0]  ext_out;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  mmio_reg_port uut (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .we_i(we), .oe_i(oe), .ub_i(ub),
    .lb_i(lb), .regmode_ni(regn), .addr_i(addr), .wdata_i(wd),
    .rdata_o(rdata), .rvalid_o(rvalid), .ext_in_i(ext_in), .ext_out_o(ext_out)
  );

  typedef struct packed {
    logic        regn;
    logic        we;
    logic        oe;
    logic        ub;
    logic        lb;
    logic [7:0]  addr;
    logic [15:0] wd;
    logic        ev;
    logic [15:0] ed;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 8'h05, 16'hA55A, 1'b0, 16'h0000, 4'd5}, // R5 write
    '{1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'h05, 16'h0000, 1'b1, 16'hA55A, 4'd3}, // R3
    '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 8'h06, 16'hFFFF, 1'b0, 16'h0000, 4'd3}, // R3
    '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'h06, 16'h1200, 1'b0, 16'h0000, 4'd3}, // R3 upper only
    '{1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'h06, 16'h0000, 1'b1, 16'h12FF, 4'd3}, // R3
    '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'h06, 16'h0034, 1'b0, 16'h0000, 4'd3}, // R3 lower only
    '{1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'h06, 16'h0000, 1'b1, 16'h1234, 4'd3}, // R3
    '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'h05, 16'h0000, 1'b1, 16'hA500, 4'd4}, // R4
    '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8'h05, 16'h0000, 1'b1, 16'h005A, 4'd4}, // R4
    '{1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h05, 16'h0000, 1'b0, 16'h0000, 4'd5}, // R5 no oe
    '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 8'h00, 16'h0F0F, 1'b0, 16'h0000, 4'd2}, // R2
    '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 8'h01, 16'h7777, 1'b0, 16'h0000, 4'd2}, // R2
    '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 8'hFF, 16'hCAFE, 1'b0, 16'h0000, 4'd2}, // R2
    '{1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'h00, 16'h0000, 1'b1, 16'h0F0F, 4'd2}, // R2
    '{1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'h01, 16'h0000, 1'b1, 16'h7777, 4'd2}, // R2
    '{1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'hFF, 16'h0000, 1'b1, 16'hCAFE, 4'd2}  // R2
  };

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // drive one access at a negedge; returns at the next negedge with outputs settled
  task automatic acc(input logic c, input logic w, input logic o, input logic u,
                     input logic l, input logic r, input logic [7:0] a, input logic [15:0] d);
    cs = c; we = w; oe = o; ub = u; lb = l; regn = r; addr = a; wd = d;
    @(negedge clk);
    cs = 0; we = 0; oe = 0;
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk("R1 ext_out in reset", 16'(ext_out), 16'h0);
    chk("R1 rvalid in reset", 16'(rvalid), 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rdata after reset", rdata, 16'h0);
    chk("R1 ext_out after reset", 16'(ext_out), 16'h0);

    for (int i = 0; i < NV; i++) begin
      acc(1'b1, VECS[i].we, VECS[i].oe, VECS[i].ub, VECS[i].lb, VECS[i].regn,
          VECS[i].addr, VECS[i].wd);
      chk($sformatf("R%0d vec%0d rvalid", VECS[i].req, i), 16'(rvalid), 16'(VECS[i].ev));
      chk($sformatf("R%0d vec%0d rdata", VECS[i].req, i), rdata, VECS[i].ed);
      chk($sformatf("R2 vec%0d ext_out untouched", i), 16'(ext_out), 16'h0);
    end

    // R5 idle cycle after a read clears outputs
    acc(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'h05, 16'h0);
    @(negedge clk);
    chk("R5 rvalid after idle", 16'(rvalid), 16'h0);
    chk("R5 rdata after idle", rdata, 16'h0);

    // R6 synchronizer latency
    ext_in = 2'b10;
    acc(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 16'h0);
    chk("R6 input not yet visible", rdata, 16'h0000);
    chk("R6 valid", 16'(rvalid), 16'h1);
    @(negedge clk);
    @(negedge clk);
    acc(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 16'h0);
    chk("R6 input visible", rdata, 16'h0002);
    ext_in = 2'b01;
    repeat (3) @(negedge clk);
    acc(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 16'h0);
    chk("R6 input second pattern", rdata, 16'h0001);

    // R7 output register write and readback
    acc(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'h01, 16'hFF15);
    chk("R7 ext_out after write", 16'(ext_out), 16'h0015);
    acc(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h01, 16'h0);
    chk("R7 register readback", rdata, 16'h0015);

    // R8 write-through, both lanes then lower lane only
    acc(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'h01, 16'h0);
    chk("R8 memory word 1 both lanes", rdata, 16'hFF15);
    acc(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h01, 16'h3303);
    chk("R8 ext_out lower lane write", 16'(ext_out), 16'h0003);
    acc(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'h01, 16'h0);
    chk("R8 memory word 1 lower lane", rdata, 16'hFF03);

    // R9 register access without lower lane
    acc(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h01, 16'h001F);
    chk("R9 ext_out unchanged", 16'(ext_out), 16'h0003);
    acc(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'h01, 16'h0);
    chk("R9 memory word 1 unchanged", rdata, 16'hFF03);
    acc(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h01, 16'h0);
    chk("R9 register read rvalid", 16'(rvalid), 16'h0);

    // R10 overlay mode writes at 0 and accesses at 2+ reach memory
    acc(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 16'h4444);
    acc(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'h00, 16'h0);
    chk("R10 write at 0 in overlay", rdata, 16'h4444);
    acc(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'h05, 16'h0);
    chk("R10 read at 5 in overlay", rdata, 16'hA55A);

    // R11 deselected accesses
    acc(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'h05, 16'h0000);
    acc(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'h01, 16'h0000);
    chk("R11 ext_out unchanged", 16'(ext_out), 16'h0003);
    acc(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'h05, 16'h0);
    chk("R11 rvalid when deselected", 16'(rvalid), 16'h0);
    acc(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'h05, 16'h0);
    chk("R11 memory unchanged", rdata, 16'hA55A);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule